// File: doc/BRIEF.md
# Adaptive Decision Feedback Equalizer

This block is a digital model of the feedback equalizer in a serial receiver. It accepts one signed fixed-point sample per unit interval, after gain control. It keeps the most recent hard decisions in a short history. For each sample it subtracts an estimate of the trailing inter-symbol interference. That estimate is the sum of the tap weights, each multiplied by the past decision it belongs to. The block then slices the cleaned value into a bit.

A sign-error rule adapts the tap weights. The error is the magnitude of the equalized value minus a programmed target amplitude. The sign of that error, the chosen step size and the past decision together push one tap up or down. The taps are visited in turn, starting with the first post-cursor tap, and each one is clamped to a programmable range.

Samples, taps and the threshold use a Q1.10 signed format with 10 fraction bits. The feedback sum and the equalized value carry 3 extra integer bits, so they cannot wrap. The decision, the equalized value, the error sign and a valid pulse are registered and appear one cycle after the sample strobe.

Top module: `dfe_adapt`

## Requirements
- R1: There are five feedback taps. Tap k (k = 1..5, packed at `taps_out[(k-1)*12 +: 12]`) is weighted by the decision made k accepted samples earlier. A decision of 1 counts as +1 and a decision of 0 counts as -1.
- R2: The equalized value is the sign-extended sample minus the sum over k of tap k times its signed past decision. It is computed in 15-bit signed arithmetic.
- R3: The decision is 1 when the equalized value is strictly greater than the signed `slice_thr`, and 0 otherwise. Example with taps 179 and 77, the two previous decisions both 1 and a sample of 358: the equalized value is 102, and with a threshold of 256 the decision is 0.
- R4: `out_vld` is high in exactly the cycle after an accepted `smp_vld`. In that same cycle `dec_out`, `eq_out` and `err_neg` show the results for that sample.
- R5: `err_neg` is 1 when the magnitude of the equalized value is below `amp_ref`, and 0 otherwise.
- R6: Each accepted sample with `adapt_en` high updates exactly one tap and then moves a round-robin pointer to the next tap. The order is tap 1, tap 2, … tap 5, then tap 1 again. The update is h += step × sign(error) × d, where d is the signed past decision of that tap. An error of zero leaves the tap unchanged but still moves the pointer.
- R7: After an update, a tap is clamped to the range from -`tap_lim` to +`tap_lim`.
- R8: Reset (synchronous, active high) clears the taps, the decision history, the outputs and the valid pulse. It also sets the pointer to tap 1.
- R9: While `adapt_en` is low, accepted samples leave the taps and the pointer unchanged.
- R10: A cycle without `smp_vld` changes neither the history, the taps nor `dec_out`/`eq_out`/`err_neg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe, one per unit interval |
| smp_in | input | 12 | Signed Q1.10 input sample |
| slice_thr | input | 12 | Signed slicer threshold |
| amp_ref | input | 11 | Target amplitude (unsigned, Q1.10 magnitude) |
| adapt_en | input | 1 | Enables tap adaptation |
| step | input | 11 | Adaptation step size (unsigned) |
| tap_lim | input | 11 | Tap magnitude limit (unsigned) |
| dec_out | output | 1 | Sliced decision |
| out_vld | output | 1 | Result valid, one cycle after the strobe |
| err_neg | output | 1 | Error sign: magnitude below target |
| eq_out | output | 15 | Signed equalized value |
| taps_out | output | 60 | Five 12-bit signed taps, tap 1 in the low bits |

## Verification
All four result outputs, and any tap change, take effect on the clock edge that accepts the strobe. They can therefore be observed one cycle after it. The bench drives inputs on the falling edge. After each rising edge it advances a behavioural model by that edge's inputs, then compares every output at the next falling edge. This means each result is checked exactly one cycle after its strobe. Directed sequences first preload taps through adaptation. They then check the slicer example, the order in which taps see the decision history, saturation, and the hold conditions. A random phase runs after these.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  typedef enum logic [1:0] {
    SGN_ZERO = 2'd0,
    SGN_POS  = 2'd1,
    SGN_NEG  = 2'd2
  } err_sgn_t;
endpackage

// File: rtl/dfe_hist.sv
module dfe_hist #(
  parameter int NTAPS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [NTAPS-1:0] hist
);
  // hist[0] holds the newest decision, hist[k] the one k+1 samples back
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (shift_en) begin
      hist <= {hist[NTAPS-2:0], din};
    end
  end
endmodule

// File: rtl/dfe_fb_sum.sv
module dfe_fb_sum #(
  parameter int NTAPS = 5,
  parameter int DW    = 12,
  parameter int GUARD = 3,
  localparam int EW   = DW + GUARD
) (
  input  logic [NTAPS*DW-1:0] taps,
  input  logic [NTAPS-1:0]    hist,
  output logic signed [EW-1:0] fb
);
  logic signed [EW-1:0] term [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_term
    logic signed [DW-1:0] t;
    logic signed [EW-1:0] t_ext;
    assign t     = taps[k*DW +: DW];
    assign t_ext = {{GUARD{t[DW-1]}}, t};
    assign term[k] = hist[k] ? t_ext : -t_ext;
  end

  always_comb begin
    fb = '0;
    for (int k = 0; k < NTAPS; k++) begin
      fb = fb + term[k];
    end
  end
endmodule

// File: rtl/dfe_tap_adapt.sv
module dfe_tap_adapt
  import dfe_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int DW    = 12,
  localparam int PW   = (NTAPS > 1) ? $clog2(NTAPS) : 1,
  localparam int XW   = DW + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd_en,
  input  err_sgn_t            esg,
  input  logic [NTAPS-1:0]    hist,
  input  logic [DW-2:0]       step,
  input  logic [DW-2:0]       lim,
  output logic [NTAPS*DW-1:0] taps
);
  logic [PW-1:0] ptr;
  logic signed [XW-1:0] lim_p, lim_n, dlt;

  assign lim_p = {3'b000, lim};
  assign lim_n = -lim_p;
  assign dlt   = {3'b000, step};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (upd_en) begin
      ptr <= (ptr == PW'(NTAPS - 1)) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [DW-1:0] h;
    logic signed [XW-1:0] cur, nxt, sat;
    logic                 up;

    // push up when sign(error) and the past decision agree
    assign up  = (esg == SGN_POS) == hist[k];
    assign cur = {{2{h[DW-1]}}, h};

    always_comb begin
      nxt = up ? cur + dlt : cur - dlt;
      if (nxt > lim_p)      sat = lim_p;
      else if (nxt < lim_n) sat = lim_n;
      else                  sat = nxt;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        h <= '0;
      end else if (upd_en && (ptr == PW'(k)) && (esg != SGN_ZERO)) begin
        h <= DW'(sat);
      end
    end

    assign taps[k*DW +: DW] = h;
  end
endmodule

// File: rtl/dfe_adapt.sv
module dfe_adapt
  import dfe_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int DW    = 12,
  parameter int GUARD = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      smp_vld,
  input  logic signed [DW-1:0]      smp_in,
  input  logic signed [DW-1:0]      slice_thr,
  input  logic [DW-2:0]             amp_ref,
  input  logic                      adapt_en,
  input  logic [DW-2:0]             step,
  input  logic [DW-2:0]             tap_lim,
  output logic                      dec_out,
  output logic                      out_vld,
  output logic                      err_neg,
  output logic signed [DW+GUARD-1:0] eq_out,
  output logic [NTAPS*DW-1:0]       taps_out
);
  localparam int EW = DW + GUARD;

  logic [NTAPS-1:0]     hist;
  logic [NTAPS*DW-1:0]  taps;
  logic signed [EW-1:0] fb, eq_c, smp_w, thr_w, mag_c, amp_w;
  logic                 dec_c;
  err_sgn_t             esg;

  dfe_fb_sum #(.NTAPS(NTAPS), .DW(DW), .GUARD(GUARD)) u_sum (
    .taps (taps),
    .hist (hist),
    .fb   (fb)
  );

  assign smp_w = {{GUARD{smp_in[DW-1]}}, smp_in};
  assign thr_w = {{GUARD{slice_thr[DW-1]}}, slice_thr};
  assign amp_w = {{(GUARD+1){1'b0}}, amp_ref};
  assign eq_c  = smp_w - fb;
  assign dec_c = eq_c > thr_w;
  assign mag_c = eq_c[EW-1] ? -eq_c : eq_c;

  always_comb begin
    if (mag_c > amp_w)      esg = SGN_POS;
    else if (mag_c < amp_w) esg = SGN_NEG;
    else                    esg = SGN_ZERO;
  end

  dfe_hist #(.NTAPS(NTAPS)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (smp_vld),
    .din      (dec_c),
    .hist     (hist)
  );

  dfe_tap_adapt #(.NTAPS(NTAPS), .DW(DW)) u_adapt (
    .clk    (clk),
    .rst    (rst),
    .upd_en (smp_vld && adapt_en),
    .esg    (esg),
    .hist   (hist),
    .step   (step),
    .lim    (tap_lim),
    .taps   (taps)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      dec_out <= 1'b0;
      err_neg <= 1'b0;
      eq_out  <= '0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        dec_out <= dec_c;
        err_neg <= (esg == SGN_NEG);
        eq_out  <= eq_c;
      end
    end
  end

  assign taps_out = taps;
endmodule

// File: rtl/dfe_adapt_chk.sv
module dfe_adapt_chk #(
  parameter int NTAPS = 5,
  parameter int DW    = 12,
  parameter int GUARD = 3,
  localparam int EW   = DW + GUARD
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_vld,
  input logic                 adapt_en,
  input logic signed [DW-1:0] slice_thr,
  input logic [DW-2:0]        amp_ref,
  input logic [DW-2:0]        tap_lim,
  input logic                 dec_out,
  input logic                 out_vld,
  input logic                 err_neg,
  input logic signed [EW-1:0] eq_out,
  input logic [NTAPS*DW-1:0]  taps_out
);
  logic [NTAPS*DW-1:0] prev_taps;
  logic [NTAPS-1:0]    chg;
  logic signed [EW-1:0] thr_w, mag_w, amp_w;

  always_ff @(posedge clk) prev_taps <= taps_out;

  assign thr_w = {{GUARD{slice_thr[DW-1]}}, slice_thr};
  assign amp_w = {{(GUARD+1){1'b0}}, amp_ref};
  assign mag_w = eq_out[EW-1] ? -eq_out : eq_out;

  a_r4_vld_after_strobe: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> out_vld);
  a_r4_no_spurious_vld: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !out_vld);
  a_r3_slice_vs_thr: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (dec_out == (eq_out > $past(thr_w))));
  a_r5_err_sign: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (err_neg == (mag_w < $past(amp_w))));
  a_r9_hold_taps: assert property (@(posedge clk) disable iff (rst)
    !(smp_vld && adapt_en) |=> $stable(taps_out));
  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(eq_out) && $stable(dec_out) && $stable(err_neg)));
  a_r6_single_tap: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);

  for (genvar k = 0; k < NTAPS; k++) begin : g_k
    logic signed [DW-1:0] h;
    logic signed [DW:0]   h_abs;
    assign h      = taps_out[k*DW +: DW];
    assign chg[k] = (taps_out[k*DW +: DW] != prev_taps[k*DW +: DW]);
    assign h_abs  = h[DW-1] ? -{h[DW-1], h} : {h[DW-1], h};
    a_r7_tap_in_range: assert property (@(posedge clk) disable iff (rst)
      chg[k] |-> (h_abs <= $signed({2'b00, $past(tap_lim)})));
  end
endmodule

bind dfe_adapt dfe_adapt_chk #(.NTAPS(NTAPS), .DW(DW), .GUARD(GUARD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_vld   (smp_vld),
  .adapt_en  (adapt_en),
  .slice_thr (slice_thr),
  .amp_ref   (amp_ref),
  .tap_lim   (tap_lim),
  .dec_out   (dec_out),
  .out_vld   (out_vld),
  .err_neg   (err_neg),
  .eq_out    (eq_out),
  .taps_out  (taps_out)
);

// File: tb/sim_dfe_adapt.sv
`timescale 1ns/1ps
module sim_dfe_adapt;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic signed [11:0] smp_in = '0;
  logic signed [11:0] slice_thr = '0;
  logic [10:0] amp_ref = '0;
  logic adapt_en = 1'b0;
  logic [10:0] step = '0;
  logic [10:0] tap_lim = 11'd1023;
  logic dec_out, out_vld, err_neg;
  logic signed [14:0] eq_out;
  logic [59:0] taps_out;

  always #10 clk = ~clk;

  dfe_adapt u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
    .slice_thr(slice_thr), .amp_ref(amp_ref), .adapt_en(adapt_en),
    .step(step), .tap_lim(tap_lim), .dec_out(dec_out), .out_vld(out_vld),
    .err_neg(err_neg), .eq_out(eq_out), .taps_out(taps_out)
  );

  int tests = 0;
  int fails = 0;
  int m_tap [5];
  bit m_hist [5];
  int m_ptr;
  int x_eq;
  bit x_dec, x_err, x_vld;

  function automatic int tap_of(int k);
    logic signed [11:0] t;
    t = taps_out[k*12 +: 12];
    return int'(t);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    int acc, e, mag, sg, d, nv, lim;
    bit dc;
    if (rst) begin
      foreach (m_tap[k]) begin m_tap[k] = 0; m_hist[k] = 0; end
      m_ptr = 0; x_eq = 0; x_dec = 0; x_err = 0; x_vld = 0;
    end else if (smp_vld) begin
      acc = 0;
      for (int k = 0; k < 5; k++) acc += m_hist[k] ? m_tap[k] : -m_tap[k];
      e = int'(smp_in) - acc;
      dc = e > int'(slice_thr);
      mag = (e < 0) ? -e : e;
      sg = (mag > int'(amp_ref)) ? 1 : ((mag < int'(amp_ref)) ? -1 : 0);
      if (adapt_en) begin
        if (sg != 0) begin
          d = m_hist[m_ptr] ? 1 : -1;
          lim = int'(tap_lim);
          nv = m_tap[m_ptr] + int'(step) * sg * d;
          if (nv > lim) nv = lim;
          if (nv < -lim) nv = -lim;
          m_tap[m_ptr] = nv;
        end
        m_ptr = (m_ptr + 1) % 5;
      end
      for (int k = 4; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = dc;
      x_eq = e; x_dec = dc; x_err = (sg < 0); x_vld = 1;
    end else begin
      x_vld = 0;
    end
  endtask

  // inputs are set at a falling edge; the model follows the next rising
  // edge and outputs are compared at the falling edge after it
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(out_vld == x_vld, "R4 out_vld", int'(out_vld), int'(x_vld));
    chk(int'(eq_out) == x_eq, "R2 eq_out", int'(eq_out), x_eq);
    chk(dec_out == x_dec, "R3 dec_out", int'(dec_out), int'(x_dec));
    chk(err_neg == x_err, "R5 err_neg", int'(err_neg), int'(x_err));
    for (int k = 0; k < 5; k++)
      chk(tap_of(k) == m_tap[k], "R6 tap vs model", tap_of(k), m_tap[k]);
  endtask

  task automatic smp(bit v, int s);
    smp_vld = v;
    smp_in = 12'(s);
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int snap_eq;
    rst = 1'b1;
    repeat (3) cyc();
    // R8 reset state
    chk(out_vld == 0 && dec_out == 0 && eq_out == 0, "R8 outputs after reset", int'(eq_out), 0);
    for (int k = 0; k < 5; k++) chk(tap_of(k) == 0, "R8 tap after reset", tap_of(k), 0);
    rst = 1'b0;

    // fill history with ones
    slice_thr = '0; adapt_en = 0;
    repeat (6) smp(1, 1000);
    chk(dec_out == 1, "R3 positive slice", int'(dec_out), 1);

    // preload taps: pointer starts at tap 1 (R6 order)
    amp_ref = '0; adapt_en = 1;
    step = 11'd179; smp(1, 1000);
    chk(tap_of(0) == 179 && tap_of(1) == 0, "R6 first update hits tap 1", tap_of(0), 179);
    step = 11'd77; smp(1, 1000);
    chk(tap_of(1) == 77, "R6 second update hits tap 2", tap_of(1), 77);
    adapt_en = 0;

    // slicer example from the requirement
    slice_thr = 12'sd256; smp(1, 358);
    chk(int'(eq_out) == 102, "R3 example equalized value", int'(eq_out), 102);
    chk(dec_out == 0, "R3 example decision", int'(dec_out), 0);

    // history order: d1 = 0, d2 = 1 -> 0 - (-179 + 77) = 102
    slice_thr = '0; smp(1, 0);
    chk(int'(eq_out) == 102, "R1 tap k sees decision k back", int'(eq_out), 102);

    // saturation
    tap_lim = 11'd200; step = 11'd100; adapt_en = 1;
    repeat (10) smp(1, 2000);
    for (int k = 0; k < 5; k++) chk(tap_of(k) == 200, "R7 clamp at +200", tap_of(k), 200);
    tap_lim = 11'd150;
    repeat (5) smp(1, 2000);
    for (int k = 0; k < 5; k++) chk(tap_of(k) == 150, "R7 clamp at +150", tap_of(k), 150);

    // adaptation disabled
    adapt_en = 0;
    smp(1, -700); smp(1, 300); smp(1, -50);
    for (int k = 0; k < 5; k++) chk(tap_of(k) == 150, "R9 taps hold", tap_of(k), 150);

    // no strobe
    adapt_en = 1; snap_eq = int'(eq_out);
    repeat (3) smp(0, 1500);
    chk(out_vld == 0, "R10 no valid without strobe", int'(out_vld), 0);
    chk(int'(eq_out) == snap_eq, "R10 eq_out holds", int'(eq_out), snap_eq);
    for (int k = 0; k < 5; k++) chk(tap_of(k) == 150, "R10 taps hold", tap_of(k), 150);

    // random phase against the model
    tap_lim = 11'd511;
    for (int i = 0; i < 3000; i++) begin
      adapt_en = ($urandom_range(0, 3) != 0);
      step = 11'($urandom_range(0, 15));
      amp_ref = 11'($urandom_range(0, 1023));
      slice_thr = 12'($urandom_range(0, 200) - 100);
      smp($urandom_range(0, 3) != 0, $urandom_range(0, 4094) - 2047);
    end

    // reset again mid-run
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
    for (int k = 0; k < 5; k++) chk(tap_of(k) == 0, "R8 taps cleared", tap_of(k), 0);
    chk(out_vld == 0, "R8 valid cleared", int'(out_vld), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule